// File: doc/BRIEF.md
# Adder with Approximate Low-Order Cells

This block adds two unsigned words and a carry-in, trading accuracy in the least significant bits for a shorter, cheaper carry path there. The word is cut into two parts. The low part is a ripple chain of approximate one-bit cells. Each cell uses a fixed, deliberately altered sum and carry table. The high part is an ordinary exact adder. It takes the carry left over from the low chain as its own carry-in.

The block is purely combinational. The outputs follow the operands with no clock and no state. `APPROX_BITS` sets how many low bits are approximate, from 0 to `WIDTH`. At 0 the block is an exact adder. At `WIDTH` the whole word is approximate and the carry-out comes from the last cell. Image, audio and learning datapaths can use it where small errors in the low bits are acceptable.

Top module: `approx_lsb_adder`

## Requirements
- R1: Bits below `APPROX_BITS` come from the approximate cell chain. Bits from `APPROX_BITS` up to `WIDTH-1` come from an exact adder.
- R2: The external carry-in `cin_i` is the carry input of the cell at bit 0.
- R3: A cell's sum output is 1 only when its inputs (a, b, carry-in) are 0,0,1 or 1,1,1. For all other inputs it is 0.
- R4: A cell's carry output is 1 for inputs (a, b, carry-in) equal to 0,1,0, 0,1,1, 1,0,1, 1,1,0 and 1,1,1. It is 0 for 0,0,0, 0,0,1 and 1,0,0.
- R5: The carry output of cell i feeds the carry input of cell i+1. The carry output of the top cell is the carry-in of the exact part.
- R6: The high part of `sum_o`, together with `cout_o`, equals the exact sum of the high operand bits plus the carry that leaves the low chain.
- R7: `cout_o` is the carry out of the exact part. When `APPROX_BITS` equals `WIDTH`, `cout_o` is the carry out of the top cell.
- R8: With `APPROX_BITS` = 0, {`cout_o`, `sum_o`} equals `a_i + b_i + cin_i` exactly.
- R9: The block holds no state. The outputs settle within the same time step as any change of `a_i`, `b_i` or `cin_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cin_i | input | 1 | Carry into the lowest cell |
| sum_o | output | WIDTH | Approximate sum |
| cout_o | output | 1 | Carry out of the most significant stage |

## Verification
The bound checker tests every low-order cell against properties of the table whenever any input changes:
- a set sum bit needs a set carry-in and equal operand bits;
- a set b bit forces the carry;
- equal operand bits pass straight to the carry.

It also tests the exact upper part against an exact sum of its operands and the carry from the chain, and it tests the exact fallback when no bits are approximate. Only the bench's scenarios can show the full table order of each cell, the placement of the carry-in at bit 0, and the ripple order across cells. They also show the boundary configurations with no approximate bits and with an all-approximate word. The bench covers these by comparing against its own model of the chain.

// File: rtl/approx_add_pkg.sv
package approx_add_pkg;

  // Truth tables indexed by {a, b, carry_in}; bit k holds the output for input value k.
  localparam logic [7:0] CELL_SUM_LUT   = 8'h82;
  localparam logic [7:0] CELL_CARRY_LUT = 8'hEC;

  function automatic logic cell_sum(input logic a, input logic b, input logic c);
    return CELL_SUM_LUT[{a, b, c}];
  endfunction

  function automatic logic cell_carry(input logic a, input logic b, input logic c);
    return CELL_CARRY_LUT[{a, b, c}];
  endfunction

endpackage

// File: rtl/approx_fa_cell.sv
module approx_fa_cell
  import approx_add_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  assign s_o = cell_sum(a_i, b_i, c_i);
  assign c_o = cell_carry(a_i, b_i, c_i);

endmodule

// File: rtl/approx_low_chain.sv
module approx_low_chain #(
  parameter int BITS = 6
) (
  input  logic [BITS-1:0] a_i,
  input  logic [BITS-1:0] b_i,
  input  logic            cin_i,
  output logic [BITS-1:0] sum_o,
  output logic [BITS-1:0] cell_ci_o,
  output logic [BITS-1:0] cell_co_o
);

  for (genvar i = 0; i < BITS; i++) begin : g_cell
    if (i == 0) begin : g_first
      assign cell_ci_o[i] = cin_i;
    end else begin : g_next
      assign cell_ci_o[i] = cell_co_o[i-1];
    end

    approx_fa_cell u_cell (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (cell_ci_o[i]),
      .s_o (sum_o[i]),
      .c_o (cell_co_o[i])
    );
  end

endmodule

// File: rtl/exact_high_adder.sv
module exact_high_adder #(
  parameter int BITS = 10
) (
  input  logic [BITS-1:0] a_i,
  input  logic [BITS-1:0] b_i,
  input  logic            cin_i,
  output logic [BITS-1:0] sum_o,
  output logic            cout_o
);

  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{BITS{1'b0}}, cin_i};

endmodule

// File: rtl/approx_lsb_adder.sv
module approx_lsb_adder #(
  parameter int WIDTH       = 16,
  parameter int APPROX_BITS = 6
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int HIGH_BITS = WIDTH - APPROX_BITS;
  localparam int LOW_W     = (APPROX_BITS > 0) ? APPROX_BITS : 1;
  localparam int HIGH_W    = (HIGH_BITS > 0) ? HIGH_BITS : 1;

  // Named internal events for the checker.
  logic [LOW_W-1:0] cell_ci;
  logic [LOW_W-1:0] cell_co;
  logic [LOW_W-1:0] low_sum;
  logic             bridge_c;

  if (APPROX_BITS > 0) begin : g_low
    approx_low_chain #(.BITS(APPROX_BITS)) u_low (
      .a_i       (a_i[APPROX_BITS-1:0]),
      .b_i       (b_i[APPROX_BITS-1:0]),
      .cin_i     (cin_i),
      .sum_o     (low_sum),
      .cell_ci_o (cell_ci),
      .cell_co_o (cell_co)
    );
    assign bridge_c                 = cell_co[APPROX_BITS-1];
    assign sum_o[APPROX_BITS-1:0]   = low_sum;
  end else begin : g_no_low
    assign cell_ci  = '0;
    assign cell_co  = '0;
    assign low_sum  = '0;
    assign bridge_c = cin_i;
  end

  if (HIGH_BITS > 0) begin : g_high
    logic [HIGH_W-1:0] hi_sum;
    exact_high_adder #(.BITS(HIGH_BITS)) u_high (
      .a_i    (a_i[WIDTH-1:APPROX_BITS]),
      .b_i    (b_i[WIDTH-1:APPROX_BITS]),
      .cin_i  (bridge_c),
      .sum_o  (hi_sum),
      .cout_o (cout_o)
    );
    assign sum_o[WIDTH-1:APPROX_BITS] = hi_sum;
  end else begin : g_no_high
    assign cout_o = bridge_c;
  end

endmodule

// File: rtl/approx_lsb_adder_chk.sv
module approx_lsb_adder_chk #(
  parameter int WIDTH       = 16,
  parameter int APPROX_BITS = 6
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [((APPROX_BITS > 0) ? APPROX_BITS : 1)-1:0] cell_ci,
  input logic [((APPROX_BITS > 0) ? APPROX_BITS : 1)-1:0] cell_co,
  input logic             bridge_c
);

  localparam int HIGH_BITS = WIDTH - APPROX_BITS;

  always_comb begin
    for (int i = 0; i < APPROX_BITS; i++) begin
      // R3: a set sum bit needs carry-in 1 and equal operand bits
      a_r3_sum_needs_cin: assert (!sum_o[i] || (cell_ci[i] && (a_i[i] == b_i[i])));
      // R4: b set forces the cell carry
      a_r4_b_forces_carry: assert (!b_i[i] || cell_co[i]);
      // R4: equal operand bits pass to the carry
      a_r4_equal_ops_carry: assert ((a_i[i] != b_i[i]) || (cell_co[i] == b_i[i]));
    end
  end

  if (HIGH_BITS > 0) begin : g_hi_chk
    always_comb begin
      // R6: exact upper part
      a_r6_exact_high: assert ({cout_o, sum_o[WIDTH-1:APPROX_BITS]} ==
        ({1'b0, a_i[WIDTH-1:APPROX_BITS]} + {1'b0, b_i[WIDTH-1:APPROX_BITS]} +
         {{HIGH_BITS{1'b0}}, bridge_c}));
    end
  end

  if (APPROX_BITS == 0) begin : g_exact_chk
    always_comb begin
      // R8: fully exact configuration
      a_r8_exact_fallback: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}));
    end
  end

endmodule

bind approx_lsb_adder approx_lsb_adder_chk #(
  .WIDTH       (WIDTH),
  .APPROX_BITS (APPROX_BITS)
) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .cin_i    (cin_i),
  .sum_o    (sum_o),
  .cout_o   (cout_o),
  .cell_ci  (cell_ci),
  .cell_co  (cell_co),
  .bridge_c (bridge_c)
);

// File: tb/approx_lsb_adder_bench.sv
module approx_lsb_adder_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Main instance: 16 bits, 6 approximate.
  logic [15:0] a, b, s;
  logic        ci, co;
  approx_lsb_adder #(.WIDTH(16), .APPROX_BITS(6)) u_approx_lsb_adder (
    .a_i(a), .b_i(b), .cin_i(ci), .sum_o(s), .cout_o(co));

  // Exact configuration: no approximate bits.
  logic [15:0] ea, eb, es;
  logic        eci, eco;
  approx_lsb_adder #(.WIDTH(16), .APPROX_BITS(0)) u_exact (
    .a_i(ea), .b_i(eb), .cin_i(eci), .sum_o(es), .cout_o(eco));

  // Fully approximate configuration: 8 of 8 bits.
  logic [7:0] fa, fb, fs;
  logic       fci, fco;
  approx_lsb_adder #(.WIDTH(8), .APPROX_BITS(8)) u_full (
    .a_i(fa), .b_i(fb), .cin_i(fci), .sum_o(fs), .cout_o(fco));

  // Bench model: boolean form of the cell, exact full adders above.
  function automatic logic [16:0] ref_add(input logic [15:0] x, input logic [15:0] y,
                                          input logic cin, input int w, input int l);
    logic [16:0] r;
    logic c;
    r = '0;
    c = cin;
    for (int i = 0; i < w; i++) begin
      if (i < l) begin
        r[i] = c & ~(x[i] ^ y[i]);
        c    = y[i] | (x[i] & c);
      end else begin
        r[i] = x[i] ^ y[i] ^ c;
        c    = (x[i] & y[i]) | (x[i] & c) | (y[i] & c);
      end
    end
    r[w] = c;
    return r;
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_main(input logic [15:0] x, input logic [15:0] y, input logic c);
    @(posedge clk);
    a = x; b = y; ci = c;
    @(negedge clk);
    check("R1/R5/R6 main", {co, s}, ref_add(x, y, c, 16, 6));
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [15:0] x, y;
    logic c;
    seed = 32'd12345;
    void'($urandom(seed));
    a = '0; b = '0; ci = 1'b0;
    ea = '0; eb = '0; eci = 1'b0;
    fa = '0; fb = '0; fci = 1'b0;
    @(negedge clk);
    // Idle state with all-zero operands
    check("R9 zero inputs", {co, s}, 17'd0);

    // R2: carry-in enters bit 0 (cell input 0,0,1 gives sum 1, carry 0)
    drive_main(16'h0000, 16'h0000, 1'b1);
    check("R2 cin at bit0", {co, s}, 17'h00001);

    // R3 and R4: sweep each cell table row on bit 0; bit 1 exposes the carry
    for (int k = 0; k < 8; k++) begin
      logic ea_b, eb_b, ec_b, exp_s, exp_c;
      ea_b = k[2]; eb_b = k[1]; ec_b = k[0];
      exp_s = (k == 1) || (k == 7);
      exp_c = (k == 2) || (k == 3) || (k == 5) || (k == 6) || (k == 7);
      @(posedge clk);
      a = {15'd0, ea_b}; b = {15'd0, eb_b}; ci = ec_b;
      @(negedge clk);
      check("R3 cell sum row", {16'd0, s[0]}, {16'd0, exp_s});
      check("R4 cell carry row", {16'd0, s[1]}, {16'd0, exp_c});
    end

    // R5: carry ripples through all six cells into the exact part
    drive_main(16'h0000, 16'h003F, 1'b0);
    check("R5 ripple into high", {co, s[15:6]}, {1'b0, 10'h001});
    drive_main(16'h003F, 16'h003F, 1'b1);
    drive_main(16'hFFFF, 16'hFFFF, 1'b1);
    // R7: carry-out from the exact part
    drive_main(16'hFFC0, 16'h0040, 1'b0);
    check("R7 cout from exact part", {16'd0, co}, 17'd1);

    for (int n = 0; n < 3000; n++) begin
      x = 16'($urandom); y = 16'($urandom); c = 1'($urandom);
      drive_main(x, y, c);
    end

    // R8: exact configuration against a true sum
    for (int n = 0; n < 1500; n++) begin
      x = 16'($urandom); y = 16'($urandom); c = 1'($urandom);
      if (n == 0) begin x = 16'hFFFF; y = 16'hFFFF; c = 1'b1; end
      @(posedge clk);
      ea = x; eb = y; eci = c;
      @(negedge clk);
      check("R8 exact", {eco, es}, {1'b0, x} + {1'b0, y} + {16'd0, c});
    end

    // R7: fully approximate width, cout from top cell
    for (int n = 0; n < 1500; n++) begin
      x = 16'($urandom); y = 16'($urandom); c = 1'($urandom);
      if (n == 0) begin x = 16'h0000; y = 16'h0080; c = 1'b0; end
      @(posedge clk);
      fa = x[7:0]; fb = y[7:0]; fci = c;
      @(negedge clk);
      check("R7 full approx", {8'd0, fco, fs}, ref_add({8'd0, x[7:0]}, {8'd0, y[7:0]}, c, 8, 8));
    end

    // R9: outputs follow an input change within the same step
    @(posedge clk);
    a = 16'h1234; b = 16'h4321; ci = 1'b0;
    #0.1;
    check("R9 no state", {co, s}, ref_add(16'h1234, 16'h4321, 1'b0, 16, 6));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule